// File: doc/BRIEF.md
# Address Bus Parity Generator/Checker

This block sits in the address path of a processor bus interface and handles byte parity on a 32-bit address. While the local agent owns the address bus and presents a valid address, it drives one odd-parity bit for each address byte and asserts an output enable that models the tri-state driver.

While another agent owns the bus, the block watches for the start of a transfer that is marked global, which makes it a transfer to snoop. In that cycle it computes parity on the incoming address and compares it lane by lane with the received parity bits. It records the result in a registered per-lane syndrome and an error flag. A mismatch raises a one-cycle machine-check request when checking and machine checks are both enabled. It raises a sticky checkstop when checking is enabled and machine checks are disabled.

Top module: `addr_par_unit`

## Requirements
- R1: `par_o[k]` is the odd-parity bit of address byte k: the eight bits plus the parity bit hold an odd number of ones. Lane 0 covers `addr_i[31:24]` and lane 3 covers `addr_i[7:0]`. The output is combinational and valid in the same cycle.
- R2: `par_oe_o` is high exactly when `master_i` and `addr_vld_i` are both high, in the same cycle.
- R3: A check is qualified only in a cycle with `master_i` low, `start_i` high and `global_i` high. In any other cycle, `syn_o` and `err_o` keep their values and no machine check or checkstop is raised.
- R4: After the clock edge that ends a qualified cycle, `syn_o[k]` is 1 exactly when received `par_i[k]` differs from the computed parity of lane k, and `err_o` is 1 exactly when any lane differs. Both are recorded whatever the enable inputs are and are held until the next qualified check.
- R5: A qualified mismatch with `chk_en_i` = 1 and `mce_en_i` = 1 makes `mchk_o` high for exactly the one cycle after the edge that ends the qualified cycle.
- R6: A qualified mismatch with `chk_en_i` = 1 and `mce_en_i` = 0 sets `chkstop_o` after that edge, and it stays high until reset. No machine-check pulse is raised.
- R7: With `chk_en_i` = 0, a qualified mismatch raises neither `mchk_o` nor `chkstop_o`.
- R8: Reset (`rst_ni` low) clears `syn_o`, `err_o`, `mchk_o` and `chkstop_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 32 | Address bus value |
| par_i | input | 4 | Received parity bits, lane 0 = top byte |
| master_i | input | 1 | Local agent owns the address bus |
| addr_vld_i | input | 1 | A valid address is on the bus |
| start_i | input | 1 | Transfer-start strobe |
| global_i | input | 1 | Transfer is marked for snooping |
| chk_en_i | input | 1 | Address parity checking enabled |
| mce_en_i | input | 1 | Machine checks enabled (clear: checkstop) |
| par_o | output | 4 | Computed parity to drive |
| par_oe_o | output | 1 | Parity driver enable |
| err_o | output | 1 | Last qualified check found a mismatch |
| syn_o | output | 4 | Per-lane mismatch syndrome of last qualified check |
| mchk_o | output | 1 | One-cycle machine-check request |
| chkstop_o | output | 1 | Sticky checkstop request |

## Verification
The parity field and its enable are combinational, so the bench drives them on a falling edge and samples them 1 time unit later, well before the next rising edge. The syndrome, error flag, machine-check pulse and checkstop come from registers loaded at the rising edge that ends the qualified cycle. The bench samples them 1 time unit after that edge. One cycle later, with the strobe removed, it samples again to confirm that the pulse has ended and that the syndrome and checkstop are held.

// File: rtl/addr_par_pkg.sv
package addr_par_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic logic odd_bit(input logic [BYTE_W-1:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/addr_par_gen.sv
module addr_par_gen
  import addr_par_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned LANES = ADDR_W / BYTE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [LANES-1:0]  par_o
);
  // lane 0 = most significant byte
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign par_o[k] = odd_bit(addr_i[ADDR_W-1-k*BYTE_W -: BYTE_W]);
  end
endmodule

// File: rtl/addr_par_cmp.sv
module addr_par_cmp #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES-1:0] calc_i,
  input  logic [LANES-1:0] rx_i,
  input  logic             master_i,
  input  logic             start_i,
  input  logic             global_i,
  output logic             qual_o,
  output logic [LANES-1:0] miss_o
);
  assign qual_o = ~master_i & start_i & global_i;
  assign miss_o = calc_i ^ rx_i;
endmodule

// File: rtl/addr_par_resp.sv
module addr_par_resp #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             qual_i,
  input  logic [LANES-1:0] miss_i,
  input  logic             chk_en_i,
  input  logic             mce_en_i,
  output logic             err_o,
  output logic [LANES-1:0] syn_o,
  output logic             mchk_o,
  output logic             chkstop_o
);
  logic bad;
  assign bad = qual_i & (|miss_i) & chk_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o     <= 1'b0;
      syn_o     <= '0;
      mchk_o    <= 1'b0;
      chkstop_o <= 1'b0;
    end else begin
      if (qual_i) begin
        syn_o <= miss_i;
        err_o <= |miss_i;
      end
      mchk_o <= bad & mce_en_i;
      if (bad && !mce_en_i) chkstop_o <= 1'b1;
    end
  end
endmodule

// File: rtl/addr_par_unit.sv
module addr_par_unit
  import addr_par_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned LANES = ADDR_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  par_i,
  input  logic              master_i,
  input  logic              addr_vld_i,
  input  logic              start_i,
  input  logic              global_i,
  input  logic              chk_en_i,
  input  logic              mce_en_i,
  output logic [LANES-1:0]  par_o,
  output logic              par_oe_o,
  output logic              err_o,
  output logic [LANES-1:0]  syn_o,
  output logic              mchk_o,
  output logic              chkstop_o
);
  logic [LANES-1:0] calc;
  logic [LANES-1:0] miss;
  logic             qual;

  addr_par_gen #(.ADDR_W(ADDR_W)) u_gen (
    .addr_i (addr_i),
    .par_o  (calc)
  );

  addr_par_cmp #(.LANES(LANES)) u_cmp (
    .calc_i   (calc),
    .rx_i     (par_i),
    .master_i (master_i),
    .start_i  (start_i),
    .global_i (global_i),
    .qual_o   (qual),
    .miss_o   (miss)
  );

  addr_par_resp #(.LANES(LANES)) u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .qual_i    (qual),
    .miss_i    (miss),
    .chk_en_i  (chk_en_i),
    .mce_en_i  (mce_en_i),
    .err_o     (err_o),
    .syn_o     (syn_o),
    .mchk_o    (mchk_o),
    .chkstop_o (chkstop_o)
  );

  assign par_o    = calc;
  assign par_oe_o = master_i & addr_vld_i;
endmodule

// File: rtl/addr_par_chk.sv
module addr_par_chk #(
  parameter int unsigned LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             master_i,
  input logic             addr_vld_i,
  input logic             start_i,
  input logic             global_i,
  input logic             chk_en_i,
  input logic             mce_en_i,
  input logic             par_oe_o,
  input logic             err_o,
  input logic [LANES-1:0] syn_o,
  input logic             mchk_o,
  input logic             chkstop_o
);
  // R2
  oe_needs_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_oe_o |-> (master_i && addr_vld_i));

  // R3
  syn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && global_i && !master_i) |=> ($stable(syn_o) && $stable(err_o)));

  // R4
  err_has_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (syn_o != '0));

  // R5
  mchk_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mchk_o |-> $past(!master_i && start_i && global_i && chk_en_i && mce_en_i));

  // R6
  chkstop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chkstop_o |=> chkstop_o);

  // R7
  chkstop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chkstop_o) |-> $past(chk_en_i && !mce_en_i && start_i && global_i));
endmodule

bind addr_par_unit addr_par_chk #(.LANES(LANES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .master_i   (master_i),
  .addr_vld_i (addr_vld_i),
  .start_i    (start_i),
  .global_i   (global_i),
  .chk_en_i   (chk_en_i),
  .mce_en_i   (mce_en_i),
  .par_oe_o   (par_oe_o),
  .err_o      (err_o),
  .syn_o      (syn_o),
  .mchk_o     (mchk_o),
  .chkstop_o  (chkstop_o)
);

// File: tb/sim_addr_par_unit.sv
`timescale 1ns/1ps
module sim_addr_par_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [31:0] addr_i;
  logic [3:0]  par_i;
  logic        master_i, addr_vld_i, start_i, global_i, chk_en_i, mce_en_i;
  logic [3:0]  par_o, syn_o;
  logic        par_oe_o, err_o, mchk_o, chkstop_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  addr_par_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .par_i(par_i),
    .master_i(master_i), .addr_vld_i(addr_vld_i), .start_i(start_i),
    .global_i(global_i), .chk_en_i(chk_en_i), .mce_en_i(mce_en_i),
    .par_o(par_o), .par_oe_o(par_oe_o), .err_o(err_o), .syn_o(syn_o),
    .mchk_o(mchk_o), .chkstop_o(chkstop_o)
  );

  function automatic logic [3:0] model_par(input logic [31:0] a);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += int'(a[31 - 8*k - b]);
      p[k] = (ones % 2 == 0);
    end
    return p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic idle();
    master_i = 1'b0; addr_vld_i = 1'b0; start_i = 1'b0; global_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic        exp_cs;
    addr_i = '0; par_i = '0; chk_en_i = 1'b1; mce_en_i = 1'b1;
    idle();
    do_reset();

    // R8 reset state
    #1;
    chk("R8 syn", syn_o, 0);
    chk("R8 err", err_o, 0);
    chk("R8 mchk", mchk_o, 0);
    chk("R8 chkstop", chkstop_o, 0);

    // R1, R2 exhaustive byte sweep on every lane
    for (int v = 0; v < 256; v++) begin
      @(negedge clk_i);
      a = {v[7:0], v[7:0] ^ 8'h5a, ~v[7:0], v[7:0] * 8'd3 + 8'd1};
      addr_i = a; master_i = 1'b1; addr_vld_i = 1'b1;
      #1;
      chk("R1 parity", par_o, model_par(a));
      chk("R2 oe on", par_oe_o, 1);
    end
    @(negedge clk_i);
    addr_vld_i = 1'b0; #1;
    chk("R2 oe no valid", par_oe_o, 0);
    master_i = 1'b0; addr_vld_i = 1'b1; #1;
    chk("R2 oe not master", par_oe_o, 0);
    idle();

    // R4 R5 R6 R7 all lane patterns under all enable combos
    for (int cfg = 0; cfg < 4; cfg++) begin
      chk_en_i = cfg[0]; mce_en_i = cfg[1];
      do_reset();
      exp_cs = 1'b0;
      for (int pat = 0; pat < 16; pat++) begin
        @(negedge clk_i);
        a = 32'h1357_9bdf ^ (32'h0101_0101 * pat) ^ (cfg << 12);
        addr_i = a; par_i = model_par(a) ^ pat[3:0];
        master_i = 1'b0; start_i = 1'b1; global_i = 1'b1;
        @(posedge clk_i); #1;
        exp_cs = exp_cs | ((pat != 0) && cfg[0] && !cfg[1]);
        chk("R4 syndrome", syn_o, pat);
        chk("R4 err", err_o, pat != 0);
        chk("R5 R7 mchk", mchk_o, (pat != 0) && cfg[0] && cfg[1]);
        chk("R6 R7 chkstop", chkstop_o, exp_cs);
        @(negedge clk_i);
        start_i = 1'b0; par_i = ~par_i;
        @(posedge clk_i); #1;
        chk("R5 pulse ends", mchk_o, 0);
        chk("R3 syn held", syn_o, pat);
        chk("R6 chkstop held", chkstop_o, exp_cs);
      end
    end

    // R3 unqualified cycles ignored
    chk_en_i = 1'b1; mce_en_i = 1'b0;
    do_reset();
    @(negedge clk_i);
    a = 32'hdead_beef; addr_i = a; par_i = model_par(a);
    start_i = 1'b1; global_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R3 clean check", syn_o, 0);
    for (int m = 0; m < 3; m++) begin
      @(negedge clk_i);
      par_i = ~model_par(a);
      master_i = (m == 0); start_i = (m != 2); global_i = (m != 1);
      @(posedge clk_i); #1;
      chk("R3 ignored syn", syn_o, 0);
      chk("R3 ignored err", err_o, 0);
      chk("R3 ignored chkstop", chkstop_o, 0);
    end
    idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule